// File: doc/BRIEF.md
# SPI Slave Pause Controller

This block sits between the raw pins of an SPI slave and the serial engine that shifts bits in and out. It brings the chip-select, serial clock, serial data input and an active-low pause request into the system clock domain. The system clock oversamples the serial clock. The block then gives the engine one-cycle enables for each rising and falling serial clock edge it should act on. It also gives a data-output enable that the engine's own drive request must pass through.

When the pause request goes low, the block freezes the transaction in progress without resetting it. While the freeze holds, serial clock edges reach the engine as nothing and the output is released. The engine therefore keeps its bit position and continues from that exact bit once the pause ends. Whether a pause begins at once or is deferred depends on the level of the serial clock at the moment of the request. The same level decides whether a release of the request resumes communication. Raising chip-select during a pause abandons both the pause and the sequence, and the block reports this with a one-cycle abort pulse.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After reset, `paused`, `so_oe`, `sck_rise_en`, `sck_fall_en` and `seq_abort` are all low.
- R2: Each input passes through SYNC_STAGES flops before the block uses it. While selected and running, every synchronized rising serial clock edge yields exactly one `sck_rise_en` pulse. Every synchronized falling edge yields exactly one `sck_fall_en` pulse. `si_bit` is the serial input delayed by the same SYNC_STAGES flops.
- R3: If the pause request is low while selected, running and with the serial clock low, `paused` goes high on the next cycle.
- R4: While `paused` is high, no `sck_rise_en` or `sck_fall_en` pulse is produced, whatever the serial clock does.
- R5: A rising edge of the pause request while paused, selected and with the serial clock low clears `paused` on the next cycle. After that, edges are forwarded again.
- R6: A pause requested while the serial clock is high is deferred. `paused` rises on the cycle after the next synchronized falling edge, and that falling edge is not forwarded.
- R7: `so_oe` is high only when `eng_so_req` is high, chip-select is low, the synchronized pause request is high and the block is not paused. The output is released as soon as the request goes low, whatever the serial clock level.
- R8: A release of the pause request while the serial clock is high leaves the block paused. Only a later rising edge of the request seen with the serial clock low resumes it.
- R9: If the pause request returns high before the deferred falling edge arrives, the pause is cancelled, `paused` stays low and that falling edge is forwarded.
- R10: A rise of chip-select while paused or waiting for a deferred pause gives a single-cycle `seq_abort` pulse. The block returns to running, with `paused` low.
- R11: While chip-select is high, a low pause request neither pauses the block nor pulses `seq_abort`.
- R12: While chip-select is high, no edge enable is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_pin | input | 1 | Raw chip-select pin, active low |
| sck_pin | input | 1 | Raw serial clock pin |
| si_pin | input | 1 | Raw serial data input pin |
| hold_n_pin | input | 1 | Raw pause request pin, active low |
| eng_so_req | input | 1 | Engine wants to drive the serial output |
| sck_rise_en | output | 1 | One-cycle enable for a forwarded rising serial clock edge |
| sck_fall_en | output | 1 | One-cycle enable for a forwarded falling serial clock edge |
| si_bit | output | 1 | Synchronized serial input, aligned with the edge enables |
| so_oe | output | 1 | Gated serial output enable |
| paused | output | 1 | High while a pause is in effect |
| seq_abort | output | 1 | One-cycle pulse when chip-select rises during a pause or deferred pause |

## Verification
Every cycle, the assertions check the following: no edge is forwarded while paused or deselected, and the output is released whenever the synchronized request is low. They also check that a pause only takes effect from a low serial clock, that a paused block with a high serial clock stays paused, and that an abort is a lone pulse followed by running. The orderings that need a history of several pin changes can only be shown by the bench's scenarios. These are the deferred pause that swallows its falling edge, the failed resume followed by a good one, the cancelled deferral that forwards its edge, and a request made while deselected. The bench's cycle model also confirms the synchronizer latency of every enable.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

   typedef enum logic [1:0] {
      HS_RUN    = 2'd0,
      HS_ARMED  = 2'd1,
      HS_PAUSED = 2'd2
   } hold_state_t;

   localparam int PIN_W   = 4;
   localparam int PIN_CS  = 0;
   localparam int PIN_SCK = 1;
   localparam int PIN_HLD = 2;
   localparam int PIN_SI  = 3;

endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
   parameter int          STAGES  = 2,
   parameter int          W       = 4,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] lvl,
   output logic [W-1:0] lvl_prev
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_hold_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("spi_hold_sync: W must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stg;
   logic [W-1:0]             prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg    <= {STAGES{RST_VAL}};
         prev_q <= RST_VAL;
      end else begin
         stg    <= {stg[STAGES-2:0], d};
         prev_q <= stg[STAGES-1];
      end
   end

   generate
      for (genvar b = 0; b < W; b++) begin : g_bit
         assign lvl[b]      = stg[STAGES-1][b];
         assign lvl_prev[b] = prev_q[b];
      end
   endgenerate

endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm
   import spi_hold_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_s,
   input  logic cs_n_p,
   input  logic sck_s,
   input  logic sck_p,
   input  logic hold_s,
   input  logic hold_p,
   input  logic so_req,
   output logic rise_en,
   output logic fall_en,
   output logic so_oe,
   output logic paused,
   output logic abort
);

   hold_state_t st, nx;

   logic sck_rise, sck_fall, hold_rise, cs_rise, selected;

   assign sck_rise  = sck_s & ~sck_p;
   assign sck_fall  = ~sck_s & sck_p;
   assign hold_rise = hold_s & ~hold_p;
   assign cs_rise   = cs_n_s & ~cs_n_p;
   assign selected  = ~cs_n_s;

   always_comb begin
      nx = st;
      if (!selected) begin
         nx = HS_RUN;
      end else begin
         unique case (st)
            HS_RUN: begin
               if (!hold_s) nx = sck_s ? HS_ARMED : HS_PAUSED;
            end
            HS_ARMED: begin
               if (hold_s)      nx = HS_RUN;
               else if (!sck_s) nx = HS_PAUSED;
            end
            HS_PAUSED: begin
               if (hold_rise && !sck_s) nx = HS_RUN;
            end
            default: nx = HS_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= HS_RUN;
      else        st <= nx;
   end

   assign paused  = (st == HS_PAUSED);
   assign rise_en = sck_rise & selected & ~paused;
   assign fall_en = sck_fall & selected & hold_s & ~paused;
   assign so_oe   = so_req & selected & hold_s & (st == HS_RUN);
   assign abort   = cs_rise & (st != HS_RUN);

   // R4
   a_r4_quiet_paused: assert property (@(posedge clk) disable iff (!rst_n)
      paused |-> (!rise_en && !fall_en));
   // R7
   a_r7_so_released: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_s || cs_n_s) |-> !so_oe);
   // R6 and R3: a pause only takes effect from a low serial clock
   a_r6_pause_from_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(paused) |-> !$past(sck_s));
   // R8
   a_r8_stay_paused_high: assert property (@(posedge clk) disable iff (!rst_n)
      (paused && sck_s && selected) |=> paused);
   // R10
   a_r10_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!abort && !paused));
   // R12
   a_r12_gated_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |-> (!rise_en && !fall_en));

endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
   import spi_hold_pkg::*;
#(
   parameter int   SYNC_STAGES = 2,
   parameter logic SCK_IDLE    = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_pin,
   input  logic sck_pin,
   input  logic si_pin,
   input  logic hold_n_pin,
   input  logic eng_so_req,
   output logic sck_rise_en,
   output logic sck_fall_en,
   output logic si_bit,
   output logic so_oe,
   output logic paused,
   output logic seq_abort
);

   localparam logic [PIN_W-1:0] PIN_RST = {1'b0, 1'b1, SCK_IDLE, 1'b1};

   logic [PIN_W-1:0] pins, lvl, lvl_p;
   logic             unused_si_prev;

   assign pins[PIN_CS]  = cs_n_pin;
   assign pins[PIN_SCK] = sck_pin;
   assign pins[PIN_HLD] = hold_n_pin;
   assign pins[PIN_SI]  = si_pin;

   spi_hold_sync #(
      .STAGES (SYNC_STAGES),
      .W      (PIN_W),
      .RST_VAL(PIN_RST)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d       (pins),
      .lvl     (lvl),
      .lvl_prev(lvl_p)
   );

   assign si_bit         = lvl[PIN_SI];
   assign unused_si_prev = lvl_p[PIN_SI];

   spi_hold_fsm u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .cs_n_s (lvl[PIN_CS]),
      .cs_n_p (lvl_p[PIN_CS]),
      .sck_s  (lvl[PIN_SCK]),
      .sck_p  (lvl_p[PIN_SCK]),
      .hold_s (lvl[PIN_HLD]),
      .hold_p (lvl_p[PIN_HLD]),
      .so_req (eng_so_req),
      .rise_en(sck_rise_en),
      .fall_en(sck_fall_en),
      .so_oe  (so_oe),
      .paused (paused),
      .abort  (seq_abort)
   );

endmodule

// File: tb/sim_spi_hold_ctrl.sv
module sim_spi_hold_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int SYNC       = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, so_req = 1'b1;
   logic rise_en, fall_en, si_bit, so_oe, paused, seq_abort;

   int n_chk = 0, n_fail = 0;
   int n_rise = 0, n_fall = 0, n_abort = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_hold_ctrl #(.SYNC_STAGES(SYNC), .SCK_IDLE(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n), .sck_pin(sck), .si_pin(si),
      .hold_n_pin(hold_n), .eng_so_req(so_req), .sck_rise_en(rise_en),
      .sck_fall_en(fall_en), .si_bit(si_bit), .so_oe(so_oe), .paused(paused),
      .seq_abort(seq_abort));

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Reference model: pins travel through a queue of SYNC snapshots.
   // Bit 0 = chip-select, 1 = serial clock, 2 = pause request, 3 = serial input.
   logic [3:0] m_pipe[$];
   logic [3:0] m_s, m_q;
   int         m_st;  // 0 running, 1 waiting for deferred pause, 2 paused
   localparam logic [3:0] M_IDLE = 4'b0101;

   always @(posedge clk) begin
      int nx;
      if (!rst_n) begin
         m_pipe.delete();
         for (int i = 0; i < SYNC; i++) m_pipe.push_back(M_IDLE);
         m_s = M_IDLE; m_q = M_IDLE; m_st = 0;
      end else begin
         nx = m_st;
         if (m_s[0]) nx = 0;
         else if (m_st == 0 && !m_s[2]) nx = m_s[1] ? 1 : 2;
         else if (m_st == 1 && m_s[2]) nx = 0;
         else if (m_st == 1 && !m_s[1]) nx = 2;
         else if (m_st == 2 && m_s[2] && !m_q[2] && !m_s[1]) nx = 0;
         m_q = m_s;
         m_pipe.push_back({si, hold_n, sck, cs_n});
         void'(m_pipe.pop_front());
         m_s = m_pipe[0];
         m_st = nx;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         bit sel, e_rise, e_fall;
         sel    = !m_s[0];
         e_rise = m_s[1] && !m_q[1] && sel && (m_st != 2);
         e_fall = !m_s[1] && m_q[1] && sel && m_s[2] && (m_st != 2);
         chk("R2 rise enable", rise_en, e_rise);
         chk("R2 fall enable", fall_en, e_fall);
         chk("R2 si_bit", si_bit, m_s[3]);
         chk("R7 so_oe", so_oe, so_req && sel && m_s[2] && m_st == 0);
         chk("R3 paused", paused, m_st == 2);
         chk("R10 seq_abort", seq_abort, m_s[0] && !m_q[0] && m_st != 0);
         n_rise  += rise_en;
         n_fall  += fall_en;
         n_abort += seq_abort;
      end
   end

   task automatic settle();
      repeat (SYNC + 3) @(posedge clk);
      #2;
   endtask

   task automatic clr();
      n_rise = 0; n_fall = 0; n_abort = 0;
   endtask

   task automatic pulse_sck();
      sck = 1'b1; settle();
      sck = 1'b0; settle();
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      #2;
      chk("R1 paused after reset", paused, 0);
      chk("R1 so_oe after reset", so_oe, 0);
      chk("R1 rise after reset", rise_en, 0);
      chk("R1 abort after reset", seq_abort, 0);
      rst_n = 1'b1;
      settle();
      chk("R1 paused idle", paused, 0);

      // Select and run
      cs_n = 1'b0; settle();
      chk("R7 so_oe selected", so_oe, 1);
      clr(); pulse_sck();
      chk("R2 one rise per edge", n_rise, 1);
      chk("R2 one fall per edge", n_fall, 1);
      si = 1'b1; settle();
      chk("R2 si follows", si_bit, 1);
      so_req = 1'b0; settle();
      chk("R7 so_oe follows request", so_oe, 0);
      so_req = 1'b1; settle();

      // Immediate pause with SCK low
      hold_n = 1'b0; settle();
      chk("R3 immediate pause", paused, 1);
      chk("R7 so released in pause", so_oe, 0);
      clr(); pulse_sck(); pulse_sck();
      chk("R4 no rise while paused", n_rise, 0);
      chk("R4 no fall while paused", n_fall, 0);

      // Resume with SCK low
      hold_n = 1'b1; settle();
      chk("R5 resumed", paused, 0);
      chk("R5 so_oe back", so_oe, 1);
      clr(); pulse_sck();
      chk("R5 edges forwarded again", n_rise, 1);

      // Deferred pause with SCK high
      sck = 1'b1; settle();
      hold_n = 1'b0; settle();
      chk("R6 pause deferred", paused, 0);
      chk("R7 so released at once", so_oe, 0);
      clr(); sck = 1'b0; settle();
      chk("R6 paused after fall", paused, 1);
      chk("R6 starting fall swallowed", n_fall, 0);

      // Failed resume with SCK high, then a good one
      sck = 1'b1; settle();
      hold_n = 1'b1; settle();
      chk("R8 stays paused on high-SCK release", paused, 1);
      sck = 1'b0; settle();
      chk("R8 still paused after SCK low", paused, 1);
      hold_n = 1'b0; settle();
      hold_n = 1'b1; settle();
      chk("R8 resumes on qualifying edge", paused, 0);

      // Cancelled deferral
      sck = 1'b1; settle();
      hold_n = 1'b0; settle();
      hold_n = 1'b1; settle();
      clr(); sck = 1'b0; settle();
      chk("R9 cancelled pause", paused, 0);
      chk("R9 fall forwarded", n_fall, 1);

      // Chip-select rises during a pause
      hold_n = 1'b0; settle();
      chk("R10 paused before abort", paused, 1);
      clr(); cs_n = 1'b1; settle();
      chk("R10 single abort pulse", n_abort, 1);
      chk("R10 running after abort", paused, 0);

      // Deselected behaviour with the request still low
      clr(); pulse_sck();
      chk("R11 no pause while deselected", paused, 0);
      chk("R11 no abort while deselected", n_abort, 0);
      chk("R12 no rise while deselected", n_rise, 0);
      chk("R12 no fall while deselected", n_fall, 0);
      hold_n = 1'b1; settle();
      cs_n = 1'b0; settle();
      chk("R11 reselect runs", paused, 0);
      cs_n = 1'b1; settle();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule